// File: doc/BRIEF.md
# Operand-Ready Warp Issue Scheduler

The block picks, in every issue slot, one warp out of a pool of resident warps and drives that warp's next instruction to a group of lanes. Each warp brings a valid bit, a priority and a next-instruction record that names an opcode, a destination register and two source registers. A scoreboard inside the block keeps one pending bit for each register of each warp. A warp may issue only when both of its source registers are free. Among the warps that may issue, the block takes the one with the highest priority.

One instruction covers all 32 threads of a warp. The lane group is 8 lanes wide, so an issue takes four beats, and each beat reports which thread slice it drives. The next choice is made in the cycle of the last beat, which lets a new warp's first beat follow at once. When the block takes a warp it marks that warp's destination register pending. A writeback on the return port clears the bit, and a writeback counts in the same cycle that it arrives. The logic around the block watches the start pulse and the warp index, and it moves that warp's record on to its next instruction.

Top module: `warp_sched`

## Requirements
- R1: While reset is high and in the cycle after it, the block issues nothing, shows no stall, and has no register pending in any warp.
- R2: A warp is eligible only if its valid bit is set and neither source register is pending. A writeback to that register in the same cycle makes it count as free.
- R3: Among eligible warps the block always takes one whose 2-bit priority (warp w at bits [2w+1:2w] of the priority bus) is the highest.
- R4: When eligible warps tie on the highest priority, the winner is the first one found scanning upward from the warp issued before, wrapping from the top index to 0. After reset the scan starts at warp 0.
- R5: An issue lasts exactly 4 cycles. The beat goes 0, 1, 2, 3 and the thread base goes 0, 8, 16, 24. The warp, opcode and destination stay constant, the start pulse is high only on beat 0, and no new choice is made before beat 3.
- R6: If a warp is eligible in the cycle of beat 3, its beat 0 follows in the next cycle with no idle cycle in between.
- R7: In a slot where no warp is eligible, the issue valid output is low and the stall output is high.
- R8: Taking a warp sets the pending bit of its destination register. A writeback clears the bit. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: A warp whose valid bit is low is never chosen, whatever its priority.
- R10: Instruction records are 20 bits wide, with warp w at bits [20w+19:20w]. Inside a record the opcode is in bits [19:12], the destination in [11:8], source 0 in [7:4] and source 1 in [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| warp_valid_i | input | 24 | One valid bit per resident warp |
| warp_prio_i | input | 48 | 2-bit priority per warp |
| warp_instr_i | input | 480 | 20-bit next-instruction record per warp |
| wb_valid_i | input | 1 | A result is being written back |
| wb_warp_i | input | 5 | Warp index of the writeback |
| wb_reg_i | input | 4 | Register index of the writeback |
| iss_valid_o | output | 1 | A beat is being driven this cycle |
| iss_start_o | output | 1 | First beat of an issue |
| iss_warp_o | output | 5 | Warp being driven |
| iss_op_o | output | 8 | Opcode being driven |
| iss_dst_o | output | 4 | Destination register being driven |
| iss_beat_o | output | 2 | Beat number within the issue |
| iss_thread_base_o | output | 5 | First thread index covered by this beat |
| stall_o | output | 1 | Issue slot with no eligible warp |

## Verification
The assertions check four things on every cycle. Each chosen warp really is eligible. Its priority equals the highest eligible priority. Beats advance one step at a time and the warp stays fixed during an issue. A set or clear of the scoreboard shows up one cycle later. Some behaviour only the bench scenarios can show. These are the round-robin order among ties, the same-cycle writeback bypass, the set-wins rule, and the clearing of the scoreboard by reset, because each one depends on a particular history of issues and writebacks.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int OP_W     = 8;
    localparam int NUM_REGS = 16;
    localparam int REG_W    = $clog2(NUM_REGS);

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef struct packed {
        logic [OP_W-1:0] op;
        reg_idx_t        dst;
        reg_idx_t        src0;
        reg_idx_t        src1;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    typedef enum logic {
        DS_IDLE  = 1'b0,
        DS_DRIVE = 1'b1
    } disp_state_t;

    function automatic int unsigned wrap_add(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned n);
        int unsigned s;
        s = a + b;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/ws_scoreboard.sv
module ws_scoreboard
    import ws_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               set_en,
    input  logic [WW-1:0]                      set_warp,
    input  reg_idx_t                           set_reg,
    input  logic                               clr_en,
    input  logic [WW-1:0]                      clr_warp,
    input  reg_idx_t                           clr_reg,
    output logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_eff_o
);

    logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_q;

    // Writeback in this cycle already counts as free
    always_comb begin
        pend_eff_o = pend_q;
        if (clr_en && (int'(clr_warp) < NUM_WARPS))
            pend_eff_o[clr_warp][clr_reg] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_eff_o;
            if (set_en)
                pend_q[set_warp][set_reg] <= 1'b1;
        end
    end

    // Checker state: last set and clear requests
    logic          chk_set_v, chk_clr_v;
    logic [WW-1:0] chk_set_w, chk_clr_w;
    reg_idx_t      chk_set_r, chk_clr_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_set_v <= 1'b0;
            chk_clr_v <= 1'b0;
        end else begin
            chk_set_v <= set_en;
            chk_clr_v <= clr_en && (int'(clr_warp) < NUM_WARPS);
        end
        chk_set_w <= set_warp;
        chk_set_r <= set_reg;
        chk_clr_w <= clr_warp;
        chk_clr_r <= clr_reg;
    end

    AST_SB_SET_SEEN: assert property (@(posedge clk) disable iff (rst)
        chk_set_v |-> pend_q[chk_set_w][chk_set_r]); // R8

    AST_SB_CLEAR_SEEN: assert property (@(posedge clk) disable iff (rst)
        (chk_clr_v && !(chk_set_v && chk_set_w == chk_clr_w && chk_set_r == chk_clr_r))
        |-> !pend_q[chk_clr_w][chk_clr_r]); // R8

endmodule

// File: rtl/ws_picker.sv
module ws_picker
    import ws_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int PRIO_W    = 2,
    localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_WARPS-1:0]               valid_i,
    input  logic [NUM_WARPS-1:0][PRIO_W-1:0]   prio_i,
    input  instr_t [NUM_WARPS-1:0]             instr_i,
    input  logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_i,
    input  logic [WW-1:0]                      last_i,
    output logic [NUM_WARPS-1:0]               elig_o,
    output logic                               pick_valid_o,
    output logic [WW-1:0]                      pick_idx_o
);

    always_comb begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            elig_o[w] = valid_i[w]
                      & ~pend_i[w][instr_i[w].src0]
                      & ~pend_i[w][instr_i[w].src1];
        end
    end

    // Rotating scan from the warp after the last issued one; strict
    // comparison keeps the first of equal priorities.
    always_comb begin
        logic              found;
        logic [PRIO_W-1:0] best_p;
        int unsigned       best_i;
        int unsigned       idx;
        found  = 1'b0;
        best_p = '0;
        best_i = 0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            idx = wrap_add(int'(last_i), k, NUM_WARPS);
            if (elig_o[idx] && (!found || prio_i[idx] > best_p)) begin
                found  = 1'b1;
                best_p = prio_i[idx];
                best_i = idx;
            end
        end
        pick_valid_o = found;
        pick_idx_o   = WW'(best_i);
    end

    // Checker: top priority over all eligible warps
    logic [PRIO_W-1:0] chk_max_p;
    always_comb begin
        chk_max_p = '0;
        for (int w = 0; w < NUM_WARPS; w++)
            if (elig_o[w] && prio_i[w] > chk_max_p)
                chk_max_p = prio_i[w];
    end

    AST_PICK_IS_READY: assert property (@(posedge clk) disable iff (rst)
        pick_valid_o |-> (valid_i[pick_idx_o] && elig_o[pick_idx_o])); // R9

    AST_PICK_TOP_PRIO: assert property (@(posedge clk) disable iff (rst)
        pick_valid_o |-> (prio_i[pick_idx_o] == chk_max_p)); // R3

    AST_PICK_NONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pick_valid_o |-> (elig_o == '0)); // R7

endmodule

// File: rtl/ws_dispatch.sv
module ws_dispatch
    import ws_pkg::*;
#(
    parameter int NUM_WARPS     = 24,
    parameter int WARP_THREADS  = 32,
    parameter int LANES         = 8,
    localparam int WW    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int BEATS = WARP_THREADS / LANES,
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int TW    = (WARP_THREADS > 1) ? $clog2(WARP_THREADS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pick_valid_i,
    input  logic [WW-1:0] pick_idx_i,
    input  instr_t        pick_instr_i,
    output logic          take_o,
    output logic          busy_o,
    output logic [BW-1:0] beat_o,
    output logic [WW-1:0] warp_o,
    output instr_t        instr_o,
    output logic [TW-1:0] thread_base_o,
    output logic          stall_o
);

    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    disp_state_t   state_q;
    logic [BW-1:0] beat_q;
    logic [WW-1:0] warp_q;
    instr_t        instr_q;
    logic          stall_q;
    logic          slot_open;

    assign slot_open = (state_q == DS_IDLE) || (beat_q == LAST_BEAT);
    assign take_o    = slot_open && pick_valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DS_IDLE;
            beat_q  <= '0;
            warp_q  <= '0;
            instr_q <= '0;
            stall_q <= 1'b0;
        end else if (slot_open) begin
            if (pick_valid_i) begin
                state_q <= DS_DRIVE;
                beat_q  <= '0;
                warp_q  <= pick_idx_i;
                instr_q <= pick_instr_i;
                stall_q <= 1'b0;
            end else begin
                state_q <= DS_IDLE;
                beat_q  <= '0;
                stall_q <= 1'b1;
            end
        end else begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign busy_o        = (state_q == DS_DRIVE);
    assign beat_o        = beat_q;
    assign warp_o        = warp_q;
    assign instr_o       = instr_q;
    assign stall_o       = stall_q;
    assign thread_base_o = TW'(int'(beat_q) * LANES);

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy_o && beat_q != LAST_BEAT) |=> (busy_o && beat_q == $past(beat_q) + 1'b1)); // R5

    AST_WARP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && beat_q != LAST_BEAT) |=> ($stable(warp_q) && $stable(instr_q))); // R5

    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        take_o |=> (busy_o && beat_q == '0)); // R6

    AST_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
        stall_q |-> !busy_o); // R7

endmodule

// File: rtl/warp_sched.sv
module warp_sched
    import ws_pkg::*;
#(
    parameter int NUM_WARPS    = 24,
    parameter int WARP_THREADS = 32,
    parameter int LANES        = 8,
    parameter int PRIO_W       = 2,
    localparam int WW    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int BEATS = WARP_THREADS / LANES,
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int TW    = (WARP_THREADS > 1) ? $clog2(WARP_THREADS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_WARPS-1:0]          warp_valid_i,
    input  logic [NUM_WARPS*PRIO_W-1:0]   warp_prio_i,
    input  logic [NUM_WARPS*INSTR_W-1:0]  warp_instr_i,
    input  logic                          wb_valid_i,
    input  logic [WW-1:0]                 wb_warp_i,
    input  logic [REG_W-1:0]              wb_reg_i,
    output logic                          iss_valid_o,
    output logic                          iss_start_o,
    output logic [WW-1:0]                 iss_warp_o,
    output logic [OP_W-1:0]               iss_op_o,
    output logic [REG_W-1:0]              iss_dst_o,
    output logic [BW-1:0]                 iss_beat_o,
    output logic [TW-1:0]                 iss_thread_base_o,
    output logic                          stall_o
);

    logic [NUM_WARPS-1:0][PRIO_W-1:0]   prio_a;
    instr_t [NUM_WARPS-1:0]             instr_a;
    logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_eff;
    logic [NUM_WARPS-1:0]               elig;
    logic                               pick_valid, take;
    logic [WW-1:0]                      pick_idx, last_q;
    instr_t                             pick_instr, cur_instr;
    logic                               busy;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_unpack
        assign prio_a[w]  = warp_prio_i[w*PRIO_W +: PRIO_W];
        assign instr_a[w] = instr_t'(warp_instr_i[w*INSTR_W +: INSTR_W]);
    end

    assign pick_instr = instr_a[pick_idx];

    ws_scoreboard #(.NUM_WARPS(NUM_WARPS)) u_sb (
        .clk        (clk),
        .rst        (rst),
        .set_en     (take),
        .set_warp   (pick_idx),
        .set_reg    (pick_instr.dst),
        .clr_en     (wb_valid_i),
        .clr_warp   (wb_warp_i),
        .clr_reg    (wb_reg_i),
        .pend_eff_o (pend_eff)
    );

    ws_picker #(.NUM_WARPS(NUM_WARPS), .PRIO_W(PRIO_W)) u_pick (
        .clk          (clk),
        .rst          (rst),
        .valid_i      (warp_valid_i),
        .prio_i       (prio_a),
        .instr_i      (instr_a),
        .pend_i       (pend_eff),
        .last_i       (last_q),
        .elig_o       (elig),
        .pick_valid_o (pick_valid),
        .pick_idx_o   (pick_idx)
    );

    ws_dispatch #(
        .NUM_WARPS    (NUM_WARPS),
        .WARP_THREADS (WARP_THREADS),
        .LANES        (LANES)
    ) u_disp (
        .clk           (clk),
        .rst           (rst),
        .pick_valid_i  (pick_valid),
        .pick_idx_i    (pick_idx),
        .pick_instr_i  (pick_instr),
        .take_o        (take),
        .busy_o        (busy),
        .beat_o        (iss_beat_o),
        .warp_o        (iss_warp_o),
        .instr_o       (cur_instr),
        .thread_base_o (iss_thread_base_o),
        .stall_o       (stall_o)
    );

    // Round-robin origin: starts so that the first scan begins at warp 0
    always_ff @(posedge clk) begin
        if (rst)
            last_q <= WW'(NUM_WARPS - 1);
        else if (take)
            last_q <= pick_idx;
    end

    assign iss_valid_o = busy;
    assign iss_start_o = busy && (iss_beat_o == '0);
    assign iss_op_o    = cur_instr.op;
    assign iss_dst_o   = cur_instr.dst;

    AST_ISSUE_XOR_STALL: assert property (@(posedge clk) disable iff (rst)
        !(iss_valid_o && stall_o)); // R7

    AST_START_IS_TAKE: assert property (@(posedge clk) disable iff (rst)
        take |=> (iss_start_o && iss_warp_o == $past(pick_idx))); // R6

endmodule

// File: tb/tb_warp_sched.sv
module tb_warp_sched;
    import ws_pkg::*;

    localparam int NW = 24;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NW-1:0]       valid_b = '0;
    logic [1:0]          prio_b  [NW];
    logic [INSTR_W-1:0]  instr_b [NW];
    logic [NW*2-1:0]     prio_flat;
    logic [NW*INSTR_W-1:0] instr_flat;
    logic                wb_valid = 1'b0;
    logic [4:0]          wb_warp = '0;
    logic [3:0]          wb_reg = '0;

    logic       iss_valid, iss_start, stall;
    logic [4:0] iss_warp, iss_base;
    logic [7:0] iss_op;
    logic [3:0] iss_dst;
    logic [1:0] iss_beat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always_comb begin
        for (int w = 0; w < NW; w++) begin
            prio_flat[w*2 +: 2]             = prio_b[w];
            instr_flat[w*INSTR_W +: INSTR_W] = instr_b[w];
        end
    end

    warp_sched dut (
        .clk               (clk),
        .rst               (rst),
        .warp_valid_i      (valid_b),
        .warp_prio_i       (prio_flat),
        .warp_instr_i      (instr_flat),
        .wb_valid_i        (wb_valid),
        .wb_warp_i         (wb_warp),
        .wb_reg_i          (wb_reg),
        .iss_valid_o       (iss_valid),
        .iss_start_o       (iss_start),
        .iss_warp_o        (iss_warp),
        .iss_op_o          (iss_op),
        .iss_dst_o         (iss_dst),
        .iss_beat_o        (iss_beat),
        .iss_thread_base_o (iss_base),
        .stall_o           (stall)
    );

    // Selection vectors: {valid mask, high-priority mask, expected warp}
    localparam logic [55:0] VEC [10] = '{
        {24'hFFFFFF, 24'h000000, 8'd0},
        {24'hFFFFFF, 24'h000000, 8'd1},
        {24'h100021, 24'h000000, 8'd5},
        {24'h100021, 24'h000001, 8'd0},
        {24'h000088, 24'h000088, 8'd3},
        {24'h000088, 24'h000088, 8'd7},
        {24'h000088, 24'h000088, 8'd3},
        {24'h800000, 24'h000000, 8'd23},
        {24'h800001, 24'h000000, 8'd0},
        {24'h001400, 24'h001000, 8'd12}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [19:0] rec(input int op, input int dst, input int s0, input int s1);
        return {8'(op), 4'(dst), 4'(s0), 4'(s1)};
    endfunction

    task automatic defaults();
        for (int w = 0; w < NW; w++) begin
            prio_b[w]  = 2'd0;
            instr_b[w] = rec(w + 16, 15, 1, 2);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        valid_b = '0;
        wb_valid = 1'b0;
        tick();
        tick();
        chk(!iss_valid, "R1 valid in reset", iss_valid, 0);
        chk(!stall, "R1 stall in reset", stall, 0);
    endtask

    initial begin
        defaults();
        do_reset();
        rst = 1'b0;

        // Table walk: priority, round robin, beats, stall
        for (int i = 0; i < 10; i++) begin
            logic [23:0] vm, hm;
            int          ew;
            vm = VEC[i][55:32];
            hm = VEC[i][31:8];
            ew = int'(VEC[i][7:0]);
            valid_b = vm;
            for (int w = 0; w < NW; w++) prio_b[w] = hm[w] ? 2'd3 : 2'd0;
            tick();
            chk(iss_valid && iss_start, "R3/R4 issue start", iss_valid, 1);
            chk(iss_warp == 5'(ew), "R3/R4/R9 chosen warp", iss_warp, ew);
            chk(iss_op == 8'(ew + 16) && iss_dst == 4'd15, "R10 op field", iss_op, ew + 16);
            chk(iss_beat == 2'd0 && iss_base == 5'd0, "R5 beat 0", iss_base, 0);
            valid_b = '0;
            for (int b = 1; b < 4; b++) begin
                tick();
                chk(iss_valid && !iss_start && iss_beat == 2'(b), "R5 beat order", iss_beat, b);
                chk(iss_base == 5'(b * 8), "R5 thread base", iss_base, b * 8);
                chk(iss_warp == 5'(ew), "R5 warp held", iss_warp, ew);
            end
            tick();
            chk(stall && !iss_valid, "R7 stall when none eligible", stall, 1);
        end

        // Scoreboard: RAW blocking, writeback bypass, set wins
        do_reset();
        defaults();
        rst = 1'b0;
        instr_b[2] = rec(40, 5, 1, 2);
        valid_b = 24'h000004;
        tick();
        chk(iss_valid && iss_warp == 5'd2 && iss_dst == 4'd5, "R8 first issue", iss_warp, 2);
        instr_b[2] = rec(41, 6, 5, 2);
        repeat (3) tick();
        tick();
        chk(stall && !iss_valid, "R2/R8 source pending blocks", iss_valid, 0);
        tick();
        chk(stall, "R2 still blocked", stall, 1);
        wb_valid = 1'b1; wb_warp = 5'd2; wb_reg = 4'd5;
        tick();
        chk(iss_valid && iss_warp == 5'd2 && iss_op == 8'd41, "R2 same-cycle writeback ready", iss_op, 41);
        wb_valid = 1'b0;
        instr_b[2] = rec(42, 7, 6, 2);
        repeat (3) tick();
        tick();
        chk(stall && !iss_valid, "R8 destination marked pending", iss_valid, 0);
        instr_b[2] = rec(43, 7, 1, 2);
        wb_valid = 1'b1; wb_warp = 5'd2; wb_reg = 4'd7;
        tick();
        chk(iss_valid && iss_op == 8'd43, "R8 issue with clear same reg", iss_op, 43);
        wb_valid = 1'b0;
        instr_b[2] = rec(44, 9, 7, 2);
        repeat (3) tick();
        tick();
        chk(stall && !iss_valid, "R8 set wins over clear", iss_valid, 0);

        // Reset clears the scoreboard
        do_reset();
        rst = 1'b0;
        valid_b = 24'h000004;
        tick();
        chk(iss_valid && iss_op == 8'd44, "R1 scoreboard cleared by reset", iss_op, 44);

        // Back-to-back issues with no idle cycle, round robin wrap
        instr_b[2] = rec(18, 15, 1, 2);
        valid_b = 24'h000012;
        for (int t = 1; t <= 8; t++) begin
            tick();
            chk(iss_valid, "R6 no idle cycle", iss_valid, 1);
            if (t == 4) chk(iss_start && iss_warp == 5'd4, "R4/R6 next warp 4", iss_warp, 4);
            if (t == 8) chk(iss_start && iss_warp == 5'd1, "R4 wrap to warp 1", iss_warp, 1);
        end

        // Invalid warps with top priority are never chosen
        valid_b = '0;
        for (int w = 0; w < NW; w++) prio_b[w] = 2'd3;
        repeat (5) tick();
        chk(stall && !iss_valid, "R9 invalid warps ignored", iss_valid, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule